// File: doc/BRIEF.md
# Event Timer and Watchdog with a Shared Divider

This block pairs an 8-bit up-counting event timer with a watchdog. One 8-bit divider is shared between them. A control bit decides which side uses it. When the divider serves the timer, it sits in front of the timer and divides the selected count source. When it serves the watchdog, it sits after the watchdog's base counter and stretches the time-out. The timer counts either the instruction clock or edges on an external pin, and sets a sticky flag when it wraps from its top value to zero. The watchdog emits a one-cycle reset pulse when its time-out expires, unless it is serviced first.

The system clock runs at the oscillator rate. A one-hot four-phase enable bus marks the internal phases; the fourth phase ends each instruction cycle. The control register is loaded through a write strobe and powers up as all ones. There is no bus path that reads or writes the divider.

The block has no data stream, so it has no valid/ready pair. Every pin is a plain control or status signal and is sampled on the rising clock edge.

Top module: `tmr8_wdg`

## Requirements
- R1: After power-on reset, the control register holds 0xFF, the overflow flag is 0 and no watchdog pulse is given. With that setting, the timer counts falling edges of the external pin at 1:1.
- R2: With bit 5 = 0 (internal source) and bit 3 = 1 (divider on the watchdog), the timer advances once per instruction cycle. An instruction cycle ends at phase_en[3].
- R3: With bit 5 = 0 and bit 3 = 0, the divider counts instruction cycles. The timer advances once every 2^(ratio+1) of them, where ratio is control bits [2:0].
- R4: With bit 5 = 1, the pin is the source. Bit 4 = 0 selects rising edges and bit 4 = 1 selects falling edges. The pin, or the divider tap when one is used, is sampled at phase_en[1] and phase_en[3], and the pin must stay high for at least 2 clocks and low for at least 2 clocks.
- R5: With bit 5 = 1 and bit 3 = 0, the divider counts active pin edges. The timer advances once every 2^(ratio+1) of them.
- R6: A timer write loads tmr_wdata on the next clock. While bit 3 = 0, the write also clears the divider. No count is taken during the next two instruction-cycle ends.
- R7: A timer step from 0xFF to 0x00 sets ovf_flag. The flag stays set until ovf_clr is asserted, and a new overflow in the same cycle as ovf_clr wins.
- R8: While wdg_en is 1, the watchdog base counter (2^WDG_BASE_W states) advances on each wdg_tick. With bit 3 = 0, wdg_rst pulses for one cycle on every base wrap.
- R9: With bit 3 = 1, the divider counts base wraps, and wdg_rst pulses once every 2^ratio wraps.
- R10: wdg_clr clears the base counter and, while bit 3 = 1, also the divider. No pulse follows a cycle in which wdg_clr is asserted.
- R11: While wdg_en is 0, the base counter holds and wdg_rst stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | oscillator-rate clock |
| rst_n | input | 1 | active-low power-on reset |
| phase_en | input | 4 | one-hot phase enables; bit 3 ends an instruction cycle |
| ext_clk | input | 1 | external timer clock pin |
| ctrl_we | input | 1 | control register write strobe |
| ctrl_wdata | input | 8 | control value: [5] source, [4] edge, [3] divider owner, [2:0] ratio |
| tmr_we | input | 1 | timer write strobe |
| tmr_wdata | input | TMR_W | timer load value |
| ovf_clr | input | 1 | clears the overflow flag |
| wdg_en | input | 1 | watchdog enable |
| wdg_tick | input | 1 | watchdog oscillator tick |
| wdg_clr | input | 1 | watchdog service strobe |
| tmr_q | output | TMR_W | timer value |
| ovf_flag | output | 1 | sticky overflow flag |
| wdg_rst | output | 1 | watchdog reset pulse |

## Verification
The assertions assume the following about the inputs:
- phase_en is one-hot, so instruction-cycle ends never fall on adjacent clocks.
- A write strobe is a single-cycle event.
- The pin respects the two-clock high and low minimum, so no edge is lost between phase samples.

The stimulus keeps to these limits:
- It rotates phase_en in a fixed order.
- It toggles the pin every three clocks.
- It raises wdg_tick on every other clock.
- It pulses each strobe for exactly one clock.

This keeps counts periodic enough that rate windows have exact expected values.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int RATIO_W = 3;

  typedef struct packed {
    logic [1:0]         spare;
    logic               src_ext;
    logic               edge_fall;
    logic               div_wdg;
    logic [RATIO_W-1:0] ratio;
  } tw_ctrl_t;

  localparam tw_ctrl_t CTRL_POR = '1;
endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_fall,
  output logic pin_lvl,
  output logic pin_rise
);
  logic [1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[0], pin ^ edge_fall};
  end

  assign pin_lvl  = sh[0];
  assign pin_rise = sh[0] & ~sh[1];
endmodule

// File: rtl/tw_divider.sv
module tw_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [DIV_W-1:0] div_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (clr)  div_q <= '0;
    else if (step) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
  parameter int TMR_W   = 8,
  parameter int INH_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             cyc_end,
  input  logic             we,
  input  logic [TMR_W-1:0] wdata,
  input  logic             ovf_clr,
  output logic [TMR_W-1:0] q,
  output logic             ovf
);
  localparam int INH_W = $clog2(INH_CYC + 1);
  localparam logic [INH_W-1:0] INH_LOAD = INH_W'(INH_CYC);
  localparam logic [TMR_W-1:0] TOP = '1;

  logic [INH_W-1:0] inh;
  logic             step;

  assign step = evt & (inh == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        inh <= '0;
    else if (we)                       inh <= INH_LOAD;
    else if (cyc_end && inh != '0)     inh <= inh - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we)        q <= wdata;
    else if (step) q <= q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ovf <= 1'b0;
    else if (step && !we && q == TOP) ovf <= 1'b1;
    else if (ovf_clr)                 ovf <= 1'b0;
  end
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
  parameter int BASE_W  = 6,
  parameter int DIV_W   = 8,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic               clr,
  input  logic               div_wdg,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [DIV_W-1:0]   div_q,
  output logic               post_step,
  output logic               rst_pulse
);
  localparam logic [BASE_W-1:0] BASE_TOP = '1;
  localparam logic [DIV_W-1:0]  ONE_D    = 1;

  logic [BASE_W-1:0] base;
  logic [DIV_W-1:0]  pmask;
  logic              wrap, done;

  assign wrap      = en & tick & (base == BASE_TOP);
  assign pmask     = (ONE_D << ratio) - ONE_D;
  assign done      = wrap & (~div_wdg | ((div_q & pmask) == pmask));
  assign post_step = wrap & div_wdg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          base <= '0;
    else if (clr)        base <= '0;
    else if (en && tick) base <= base + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pulse <= 1'b0;
    else        rst_pulse <= done & ~clr;
  end
endmodule

// File: rtl/tmr8_wdg.sv
module tmr8_wdg
  import tw_pkg::*;
#(
  parameter int TMR_W      = 8,
  parameter int WDG_BASE_W = 6,
  parameter int INH_CYC    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       phase_en,
  input  logic             ext_clk,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wdata,
  input  logic             tmr_we,
  input  logic [TMR_W-1:0] tmr_wdata,
  input  logic             ovf_clr,
  input  logic             wdg_en,
  input  logic             wdg_tick,
  input  logic             wdg_clr,
  output logic [TMR_W-1:0] tmr_q,
  output logic             ovf_flag,
  output logic             wdg_rst
);
  localparam int DIV_W = 1 << RATIO_W;

  tw_ctrl_t          ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic              pin_lvl, pin_rise;
  logic              cyc_end, samp_ph;
  logic              samp_src, samp_r, samp_rise;
  logic              tmr_evt, src_evt;
  logic              div_step, div_clr, post_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_POR;
    else if (ctrl_we) ctrl_q <= tw_ctrl_t'(ctrl_wdata);
  end

  assign cyc_end = phase_en[3];
  assign samp_ph = phase_en[1] | phase_en[3];

  tw_pin_sync u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (ext_clk),
    .edge_fall (ctrl_q.edge_fall),
    .pin_lvl   (pin_lvl),
    .pin_rise  (pin_rise)
  );

  assign samp_src = ctrl_q.div_wdg ? pin_lvl : div_q[ctrl_q.ratio];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       samp_r <= 1'b0;
    else if (samp_ph) samp_r <= samp_src;
  end

  assign samp_rise = samp_ph & samp_src & ~samp_r;
  assign tmr_evt   = (!ctrl_q.src_ext && ctrl_q.div_wdg) ? cyc_end : samp_rise;
  assign src_evt   = ctrl_q.src_ext ? pin_rise : cyc_end;
  assign div_step  = ctrl_q.div_wdg ? post_step : src_evt;
  assign div_clr   = ctrl_q.div_wdg ? wdg_clr : tmr_we;

  tw_divider #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (div_clr),
    .step  (div_step),
    .div_q (div_q)
  );

  tw_timer #(.TMR_W(TMR_W), .INH_CYC(INH_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (tmr_evt),
    .cyc_end (cyc_end),
    .we      (tmr_we),
    .wdata   (tmr_wdata),
    .ovf_clr (ovf_clr),
    .q       (tmr_q),
    .ovf     (ovf_flag)
  );

  tw_watchdog #(.BASE_W(WDG_BASE_W), .DIV_W(DIV_W), .RATIO_W(RATIO_W)) u_wdg (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (wdg_en),
    .tick      (wdg_tick),
    .clr       (wdg_clr),
    .div_wdg   (ctrl_q.div_wdg),
    .ratio     (ctrl_q.ratio),
    .div_q     (div_q),
    .post_step (post_step),
    .rst_pulse (wdg_rst)
  );
endmodule

// File: rtl/tmr8_wdg_chk.sv
module tmr8_wdg_chk #(
  parameter int TMR_W = 8,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_we,
  input logic [TMR_W-1:0] tmr_wdata,
  input logic [TMR_W-1:0] tmr_q,
  input logic             ovf_flag,
  input logic             ovf_clr,
  input logic             wdg_rst,
  input logic             wdg_en,
  input logic             wdg_clr,
  input logic [DIV_W-1:0] div_q,
  input logic             div_wdg
);
  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_we |=> tmr_q == $past(tmr_wdata)); // R6

  AST_DIV_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_we && !div_wdg) |=> div_q == '0); // R6

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmr_we) && !tmr_we) |=> $stable(tmr_q)); // R6

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_we |=> (tmr_q == $past(tmr_q) || tmr_q == $past(tmr_q) + 1'b1)); // R2

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R7

  AST_WDG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst |=> !wdg_rst); // R8

  AST_WDG_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_clr |=> !wdg_rst); // R10

  AST_WDG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst |-> $past(wdg_en)); // R11
endmodule

bind tmr8_wdg tmr8_wdg_chk #(.TMR_W(TMR_W), .DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tmr_we    (tmr_we),
  .tmr_wdata (tmr_wdata),
  .tmr_q     (tmr_q),
  .ovf_flag  (ovf_flag),
  .ovf_clr   (ovf_clr),
  .wdg_rst   (wdg_rst),
  .wdg_en    (wdg_en),
  .wdg_clr   (wdg_clr),
  .div_q     (div_q),
  .div_wdg   (ctrl_q.div_wdg)
);

// File: tb/sim_tmr8_wdg.sv
`timescale 1ns/1ps
module sim_tmr8_wdg;
  localparam int BASE_W = 6;
  localparam int BASE_MAX = (1 << BASE_W) - 1;

  logic       clk = 0, rst_n = 0;
  logic [3:0] phase_en = 4'b0001;
  logic       ext_clk = 1, ctrl_we = 0, tmr_we = 0, ovf_clr = 0;
  logic [7:0] ctrl_wdata = 0, tmr_wdata = 0;
  logic       wdg_en = 0, wdg_tick = 0, wdg_clr = 0;
  logic [7:0] tmr_q;
  logic       ovf_flag, wdg_rst;

  int tests = 0, fails = 0, cyc = 0, pulses = 0;
  bit pin_on = 0, tick_on = 0;

  always #4 clk = ~clk;

  tmr8_wdg #(.TMR_W(8), .WDG_BASE_W(BASE_W), .INH_CYC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .ext_clk(ext_clk),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata),
    .ovf_clr(ovf_clr), .wdg_en(wdg_en), .wdg_tick(wdg_tick), .wdg_clr(wdg_clr),
    .tmr_q(tmr_q), .ovf_flag(ovf_flag), .wdg_rst(wdg_rst));

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model, updated every rising edge
  int m_ctrl, m_div, m_sh0, m_sh1, m_samp, m_tmr, m_inh, m_ovf, m_base, m_wrst;
  bit m_known;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 255; m_div = 0; m_sh0 = 0; m_sh1 = 0; m_samp = 0; m_inh = 0;
      m_ovf = 0; m_base = 0; m_wrst = 0; m_known = 0;
    end else begin
      int ratio, own, fall, ext, srcsig, pm, nsamp, ndiv, nbase, ntmr, ninh, novf;
      bit q4, sph, tev, tc, cnt, dstep, dclr;
      ratio = m_ctrl & 7; own = (m_ctrl >> 3) & 1;
      fall = (m_ctrl >> 4) & 1; ext = (m_ctrl >> 5) & 1;
      q4 = phase_en[3]; sph = phase_en[1] | phase_en[3];
      srcsig = own ? m_sh0 : ((m_div >> ratio) & 1);
      tev = (!ext && own) ? q4 : (sph && srcsig == 1 && m_samp == 0);
      tc = wdg_en && wdg_tick && m_base == BASE_MAX;
      pm = (1 << ratio) - 1;
      nsamp = sph ? srcsig : m_samp;
      dclr = own ? wdg_clr : tmr_we;
      dstep = own ? tc : (ext ? (m_sh0 == 1 && m_sh1 == 0) : q4);
      ndiv = dclr ? 0 : (dstep ? (m_div + 1) % 256 : m_div);
      nbase = wdg_clr ? 0 : ((wdg_en && wdg_tick) ? (m_base + 1) & BASE_MAX : m_base);
      m_wrst = (tc && (!own || (m_div & pm) == pm) && !wdg_clr) ? 1 : 0;
      cnt = tev && m_inh == 0;
      ntmr = tmr_we ? int'(tmr_wdata) : (cnt ? (m_tmr + 1) % 256 : m_tmr);
      novf = (cnt && !tmr_we && m_tmr == 255) ? 1 : (ovf_clr ? 0 : m_ovf);
      ninh = tmr_we ? 2 : ((q4 && m_inh > 0) ? m_inh - 1 : m_inh);
      if (tmr_we) m_known = 1;
      m_sh1 = m_sh0; m_sh0 = int'(ext_clk) ^ fall;
      m_samp = nsamp; m_div = ndiv; m_base = nbase; m_tmr = ntmr;
      m_ovf = novf; m_inh = ninh;
      if (ctrl_we) m_ctrl = int'(ctrl_wdata);
    end
  end

  // compare outputs against the model away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (wdg_rst) pulses++;
    if (rst_n) begin
      if (m_known) chk("R2 timer value vs model", int'(tmr_q), m_tmr);
      chk("R7 overflow flag vs model", int'(ovf_flag), m_ovf);
      chk("R8 watchdog pulse vs model", int'(wdg_rst), m_wrst);
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic wr_ctrl(int v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = 8'(v);
    @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_tmr(int v);
    @(negedge clk); tmr_we = 1; tmr_wdata = 8'(v);
    @(negedge clk); tmr_we = 0;
  endtask
  task automatic pulse_clr_wdg;
    @(negedge clk); wdg_clr = 1; @(negedge clk); wdg_clr = 0;
  endtask
  task automatic rate(string tag, int settle, int win, int exp);
    int v0;
    tick(settle);
    v0 = int'(tmr_q);
    tick(win);
    chk(tag, (int'(tmr_q) - v0) & 255, exp);
  endtask

  initial begin : drivers
    fork
      forever begin
        @(negedge clk);
        phase_en = {phase_en[2:0], phase_en[3]};
      end
      forever begin
        if (pin_on) begin repeat (3) @(negedge clk); ext_clk = ~ext_clk; end
        else @(negedge clk);
      end
      forever begin
        @(negedge clk);
        wdg_tick = tick_on ? ~wdg_tick : 1'b0;
      end
    join_none
  end

  initial begin : watchdog
    wait (cyc > 100000);
    fails++; tests++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    tick(5);
    chk("R1 reset overflow flag", int'(ovf_flag), 0);
    chk("R1 reset watchdog pulse", int'(wdg_rst), 0);
    @(negedge clk); rst_n = 1;
    tick(3);
    chk("R1 no pulse after reset", int'(wdg_rst), 0);

    // R1: reset setting counts falling pin edges 1:1
    wr_tmr(8'h40);
    pin_on = 1;
    rate("R1 falling edges at 1:1", 24, 96, 16);
    // R4: rising edge selected, no prescale
    wr_ctrl(8'h2F);
    rate("R4 rising edges at 1:1", 24, 96, 16);
    // R5: external with prescaler 1:2 and 1:4
    wr_ctrl(8'h20);
    rate("R5 pin prescale 1:2", 48, 96, 8);
    wr_ctrl(8'h21);
    rate("R5 pin prescale 1:4", 48, 192, 8);
    pin_on = 0;

    // R2: internal, divider on watchdog
    wr_ctrl(8'h08);
    rate("R2 internal 1:1", 16, 64, 16);
    // R3: internal prescale 1:4 and 1:8
    wr_ctrl(8'h01);
    rate("R3 internal 1:4", 64, 64, 4);
    wr_ctrl(8'h02);
    rate("R3 internal 1:8", 128, 128, 4);

    // R6: load and two-cycle hold
    wr_ctrl(8'h08);
    wr_tmr(8'h20);
    tick(8);
    chk("R6 held during inhibit", int'(tmr_q), 8'h20);
    tick(4);
    chk("R6 counts after inhibit", int'(tmr_q), 8'h21);
    // R6: writes keep the divider cleared
    wr_ctrl(8'h07);
    for (int i = 0; i < 5; i++) begin
      wr_tmr(8'h55);
      tick(200);
    end
    chk("R6 divider cleared by write", int'(tmr_q), 8'h55);

    // R7: overflow sticky and clear
    wr_ctrl(8'h08);
    wr_tmr(8'hFE);
    tick(20);
    chk("R7 wrapped value", int'(tmr_q), 8'h01);
    chk("R7 overflow set", int'(ovf_flag), 1);
    tick(40);
    chk("R7 overflow sticky", int'(ovf_flag), 1);
    @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    chk("R7 overflow cleared", int'(ovf_flag), 0);

    // R8: watchdog at 1:1 with divider on timer
    wr_ctrl(8'h00);
    wdg_en = 1; tick_on = 1;
    pulse_clr_wdg();
    tick(300);
    pulses = 0;
    tick(1280);
    chk("R8 pulses per base wrap", pulses, 10);

    // R9: postscaler 1:4 and 1:1
    wr_ctrl(8'h0A);
    pulse_clr_wdg();
    tick(600);
    pulses = 0;
    tick(2048);
    chk("R9 postscale 1:4", pulses, 4);
    wr_ctrl(8'h08);
    tick(300);
    pulses = 0;
    tick(1280);
    chk("R9 postscale 1:1", pulses, 10);

    // R10: regular service prevents any pulse
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      pulse_clr_wdg();
      tick(100);
    end
    chk("R10 serviced watchdog silent", pulses, 0);

    // R11: disabled watchdog stays silent
    wdg_en = 0;
    tick(2);
    pulses = 0;
    tick(1500);
    chk("R11 disabled watchdog silent", pulses, 0);
    wdg_en = 1;
    tick(400);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule